// File: doc/BRIEF.md
# Bulk Erase Verify Sequencer

This block is a host-side controller that runs the complete whole-array erase algorithm for a byte-wide flash device. It drives the device through a simple request/acknowledge bus master port. A single `start` pulse launches the run, and the block then works through two phases on its own.

In the first phase it preconditions every byte to 00h, using the program-and-verify sequence with a bounded number of retries per byte. In the second phase it issues erase pulses. After each pulse it sweeps erase-verify through the array and expects FFh at every address. When a byte fails, the block issues another pulse and continues the sweep from that same byte.

At the end of the run it returns the device to read mode. It then holds `done` high together with a result code and the number of erase pulses it used. The array depth, the two pulse widths in clock cycles, the program retry limit and the erase pulse limit are all parameters.

Top module: `flash_erase_seq`

## Requirements
- R1: Before the first erase is started, every address from 0 to DEPTH-1 receives a program command (40h), followed by a data write of 00h to that address, a program-verify command (C0h) and a read of that address.
- R2: If a program-verify read returns anything other than 00h, the program sequence is repeated for the same address. After PROG_TRIES failed attempts on one address, the run ends with status 3 (program failure) and no erase is ever started.
- R3: An erase is started only by two consecutive writes of 20h. Each such pair increments `pulse_cnt` by one.
- R4: At least ERASE_CYC clock cycles pass between the acceptance of the second 20h write and the next erase-verify write. At least PROG_CYC cycles pass between the acceptance of a program data write and the next program-verify write.
- R5: Each erase-verify is a write of A0h carrying an address, followed by a read of the same address. A read of FFh passes that address, and the sweep continues with the next higher address, starting from address 0 after the first pulse.
- R6: When an erase-verify read is not FFh, a new erase pulse is issued, and the sweep resumes at the address that failed.
- R7: When a verify fails after MAX_PULSES pulses, the run ends with status 2 (erase failure) and `pulse_cnt` equal to MAX_PULSES. `pulse_cnt` never exceeds MAX_PULSES.
- R8: Every run ends with exactly one write of the read command 00h. After it, `done` is high and `status` shows the result (1 pass, 2 erase failure, 3 program failure), with `pulse_cnt` holding the pulses used. `start` while `done` is high begins a new run and clears the result.
- R9: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_wr`, `bus_addr` and `bus_wdata` hold their values into the next cycle.
- R10: After reset, `done` is 0, `status` is 0, `pulse_cnt` is 0 and `bus_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle or done |
| done | output | 1 | Run finished, result valid |
| status | output | 2 | 0 none, 1 pass, 2 erase failure, 3 program failure |
| pulse_cnt | output | PCW | Erase pulses issued in this run |
| bus_req | output | 1 | Bus transaction request |
| bus_wr | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | 8 | Write data or command code |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Transaction accepted this cycle |

## Verification
The bench builds the block with DEPTH=16, PROG_CYC=3, ERASE_CYC=20, PROG_TRIES=4 and MAX_PULSES=6. With these values a full preconditioning pass and every erase-verify sweep complete within a few thousand cycles. The behavioural flash stub assigns each address a number of pulses it needs before it reads FFh, which lets the bench place failures mid-array and check that the sweep resumes at the failing address. The small pulse limit makes the erase-failure exit reachable, and a stuck byte exhausts the program retry limit so the precondition abort path is exercised too.

// File: rtl/fes_pkg.sv
package fes_pkg;

    localparam logic [7:0] CMD_READ    = 8'h00;
    localparam logic [7:0] CMD_PSETUP  = 8'h40;
    localparam logic [7:0] CMD_PVERIFY = 8'hC0;
    localparam logic [7:0] CMD_ESETUP  = 8'h20;
    localparam logic [7:0] CMD_EVERIFY = 8'hA0;
    localparam logic [7:0] BYTE_ZERO   = 8'h00;
    localparam logic [7:0] BYTE_ERASED = 8'hFF;

    typedef enum logic [3:0] {
        S_IDLE, S_PSET, S_PDAT, S_PWAIT, S_PVCMD, S_PRD,
        S_ESET1, S_ESET2, S_EWAIT, S_EVCMD, S_ERD, S_RCMD, S_DONE
    } state_t;

    typedef enum logic [1:0] {
        RES_NONE = 2'd0, RES_PASS = 2'd1, RES_EFAIL = 2'd2, RES_PFAIL = 2'd3
    } result_t;

    typedef struct packed {
        logic       req;
        logic       wr;
        logic       use_addr;
        logic [7:0] data;
    } bus_op_t;

    function automatic int cw(input int v);
        return (v < 2) ? 1 : $clog2(v);
    endfunction

    function automatic bus_op_t op_for(input state_t s);
        bus_op_t o;
        o = '{req: 1'b0, wr: 1'b0, use_addr: 1'b0, data: 8'h00};
        case (s)
            S_PSET:  o = '{req: 1'b1, wr: 1'b1, use_addr: 1'b1, data: CMD_PSETUP};
            S_PDAT:  o = '{req: 1'b1, wr: 1'b1, use_addr: 1'b1, data: BYTE_ZERO};
            S_PVCMD: o = '{req: 1'b1, wr: 1'b1, use_addr: 1'b1, data: CMD_PVERIFY};
            S_PRD:   o = '{req: 1'b1, wr: 1'b0, use_addr: 1'b1, data: 8'h00};
            S_ESET1: o = '{req: 1'b1, wr: 1'b1, use_addr: 1'b0, data: CMD_ESETUP};
            S_ESET2: o = '{req: 1'b1, wr: 1'b1, use_addr: 1'b0, data: CMD_ESETUP};
            S_EVCMD: o = '{req: 1'b1, wr: 1'b1, use_addr: 1'b1, data: CMD_EVERIFY};
            S_ERD:   o = '{req: 1'b1, wr: 1'b0, use_addr: 1'b1, data: 8'h00};
            S_RCMD:  o = '{req: 1'b1, wr: 1'b1, use_addr: 1'b0, data: CMD_READ};
            default: ;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/fes_counter.sv
module fes_counter #(
    parameter int MAXV = 15,
    parameter int W    = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         at_max
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            value <= '0;
        else if (inc && !at_max)
            value <= value + 1'b1;
    end

    assign at_max = (value == W'(MAXV));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        value <= W'(MAXV)); // R7

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!clr && !inc) |=> $stable(value)); // R6
endmodule

// File: rtl/fes_timer.sv
module fes_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [TW-1:0] len,
    output logic          fire
);
    logic [TW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (go) begin
            run <= 1'b1;
            cnt <= len;
        end else if (run) begin
            if (cnt == '0)
                run <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end
    end

    assign fire = run && (cnt == '0);

    AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (rst)
        (fire && !go) |=> !fire); // R4
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int DEPTH      = 32768,
    parameter int PROG_CYC   = 1000,
    parameter int ERASE_CYC  = 1000000,
    parameter int PROG_TRIES = 25,
    parameter int MAX_PULSES = 1000,
    localparam int AW  = cw(DEPTH),
    localparam int PCW = cw(MAX_PULSES + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    output logic           done,
    output logic [1:0]     status,
    output logic [PCW-1:0] pulse_cnt,
    output logic           bus_req,
    output logic           bus_wr,
    output logic [AW-1:0]  bus_addr,
    output logic [7:0]     bus_wdata,
    input  logic [7:0]     bus_rdata,
    input  logic           bus_ack
);
    localparam int TRW  = cw(PROG_TRIES);
    localparam int TMAX = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int TW   = cw(TMAX + 1);

    state_t  st, st_n;
    result_t res, res_n;
    bus_op_t op;
    logic    acc;

    logic           clr_a, inc_a, last_a;
    logic           clr_t, inc_t, last_t;
    logic           clr_p, inc_p, max_p;
    logic [AW-1:0]  addr;
    logic [TRW-1:0] tries;
    logic           tmr_go, tmr_fire;
    logic [TW-1:0]  tmr_len;

    assign op  = op_for(st);
    assign acc = op.req && bus_ack;

    fes_counter #(.MAXV(DEPTH - 1), .W(AW)) u_addr (
        .clk(clk), .rst(rst), .clr(clr_a), .inc(inc_a), .value(addr), .at_max(last_a));

    fes_counter #(.MAXV(PROG_TRIES - 1), .W(TRW)) u_tries (
        .clk(clk), .rst(rst), .clr(clr_t), .inc(inc_t), .value(tries), .at_max(last_t));

    fes_counter #(.MAXV(MAX_PULSES), .W(PCW)) u_pulses (
        .clk(clk), .rst(rst), .clr(clr_p), .inc(inc_p), .value(pulse_cnt), .at_max(max_p));

    fes_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .go(tmr_go), .len(tmr_len), .fire(tmr_fire));

    always_comb begin
        st_n    = st;
        res_n   = res;
        clr_a   = 1'b0; inc_a = 1'b0;
        clr_t   = 1'b0; inc_t = 1'b0;
        clr_p   = 1'b0; inc_p = 1'b0;
        tmr_go  = 1'b0;
        tmr_len = TW'(PROG_CYC);
        case (st)
            S_IDLE, S_DONE: if (start) begin
                st_n  = S_PSET;
                res_n = RES_NONE;
                clr_a = 1'b1; clr_t = 1'b1; clr_p = 1'b1;
            end
            S_PSET:  if (acc) st_n = S_PDAT;
            S_PDAT:  if (acc) begin
                st_n    = S_PWAIT;
                tmr_go  = 1'b1;
                tmr_len = TW'(PROG_CYC);
            end
            S_PWAIT: if (tmr_fire) st_n = S_PVCMD;
            S_PVCMD: if (acc) st_n = S_PRD;
            S_PRD:   if (acc) begin
                if (bus_rdata == BYTE_ZERO) begin
                    clr_t = 1'b1;
                    if (last_a) begin
                        clr_a = 1'b1;
                        st_n  = S_ESET1;
                    end else begin
                        inc_a = 1'b1;
                        st_n  = S_PSET;
                    end
                end else if (last_t) begin
                    res_n = RES_PFAIL;
                    st_n  = S_RCMD;
                end else begin
                    inc_t = 1'b1;
                    st_n  = S_PSET;
                end
            end
            S_ESET1: if (acc) st_n = S_ESET2;
            S_ESET2: if (acc) begin
                st_n    = S_EWAIT;
                inc_p   = 1'b1;
                tmr_go  = 1'b1;
                tmr_len = TW'(ERASE_CYC);
            end
            S_EWAIT: if (tmr_fire) st_n = S_EVCMD;
            S_EVCMD: if (acc) st_n = S_ERD;
            S_ERD:   if (acc) begin
                if (bus_rdata == BYTE_ERASED) begin
                    if (last_a) begin
                        res_n = RES_PASS;
                        st_n  = S_RCMD;
                    end else begin
                        inc_a = 1'b1;
                        st_n  = S_EVCMD;
                    end
                end else if (max_p) begin
                    res_n = RES_EFAIL;
                    st_n  = S_RCMD;
                end else begin
                    st_n = S_ESET1;
                end
            end
            S_RCMD:  if (acc) st_n = S_DONE;
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_IDLE;
            res <= RES_NONE;
        end else begin
            st  <= st_n;
            res <= res_n;
        end
    end

    assign done      = (st == S_DONE);
    assign status    = res;
    assign bus_req   = op.req;
    assign bus_wr    = op.wr;
    assign bus_wdata = op.data;
    assign bus_addr  = op.use_addr ? addr : '0;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_wr) && $stable(bus_addr) && $stable(bus_wdata))); // R9

    AST_DONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        done |-> (status != 2'd0)); // R8

    AST_PFAIL_NO_ERASE: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd3) |-> (pulse_cnt == '0)); // R2

    AST_EFAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd2) |-> (pulse_cnt == PCW'(MAX_PULSES))); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!bus_req && !done)); // R10
endmodule

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;
    localparam int DEPTH = 16, PROG_CYC = 3, ERASE_CYC = 20, PROG_TRIES = 4, MAX_PULSES = 6;
    localparam int AW = 4, PCW = 3;

    logic           clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic           done, bus_req, bus_wr, bus_ack = 1'b0;
    logic [1:0]     status;
    logic [PCW-1:0] pulse_cnt;
    logic [AW-1:0]  bus_addr;
    logic [7:0]     bus_wdata, bus_rdata = 8'h00;

    always #2.5 clk = ~clk;

    flash_erase_seq #(.DEPTH(DEPTH), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
        .PROG_TRIES(PROG_TRIES), .MAX_PULSES(MAX_PULSES)) uut (
        .clk(clk), .rst(rst), .start(start), .done(done), .status(status),
        .pulse_cnt(pulse_cnt), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack));

    int total = 0, bad = 0;
    int scen = 0, fault = -1;
    logic clr_stub = 1'b0;

    // stub state
    int cyc = 0, ecount, t_erase, t_pdat, fault_tries, vaddr;
    int bad_order, bad_width, bad_resume, bad_pdata, rcmd_seen, pver_seen;
    bit vseen, vfail, pend_prog;
    bit [7:0] last_cmd;
    bit prog_ok [DEPTH];

    function automatic int need(input int a);
        if (scen == 2) return (a == 5) ? 3 : (a == 11) ? 4 : 1;
        if (scen == 3) return (a == 7) ? 100 : 1;
        return 1;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (clr_stub) begin
            ecount = 0; t_erase = 0; t_pdat = 0; fault_tries = 0; vaddr = 0;
            bad_order = 0; bad_width = 0; bad_resume = 0; bad_pdata = 0;
            rcmd_seen = 0; pver_seen = 0;
            vseen = 0; vfail = 0; pend_prog = 0; last_cmd = 8'hEE;
            for (int i = 0; i < DEPTH; i++) prog_ok[i] = 1'b0;
            bus_ack <= 1'b0;
        end else if (bus_req && !bus_ack) begin
            int a;
            a = int'(bus_addr);
            bus_ack <= 1'b1;
            bus_rdata <= 8'h33;
            if (bus_wr) begin
                if (pend_prog) begin
                    pend_prog = 0; t_pdat = cyc; last_cmd = 8'hEE;
                    if (bus_wdata != 8'h00) bad_pdata++;
                    if (a == fault) fault_tries++; else prog_ok[a] = 1'b1;
                end else if (bus_wdata == 8'h20) begin
                    if (last_cmd == 8'h20) begin
                        ecount++; t_erase = cyc; last_cmd = 8'hEE;
                        for (int i = 0; i < DEPTH; i++) if (!prog_ok[i]) bad_order++;
                    end else last_cmd = 8'h20;
                end else begin
                    if (bus_wdata == 8'h40) pend_prog = 1;
                    if (bus_wdata == 8'hC0) begin
                        pver_seen++;
                        if (cyc - t_pdat < PROG_CYC) bad_width++;
                    end
                    if (bus_wdata == 8'hA0) begin
                        int ex;
                        ex = !vseen ? 0 : (vfail ? vaddr : vaddr + 1);
                        if (a != ex) bad_resume++;
                        if (cyc - t_erase < ERASE_CYC) bad_width++;
                        vaddr = a; vseen = 1;
                    end
                    if (bus_wdata == 8'h00) rcmd_seen++;
                    last_cmd = bus_wdata;
                end
            end else begin
                if (last_cmd == 8'hC0) bus_rdata <= (a == fault) ? 8'h01 : 8'h00;
                else if (last_cmd == 8'hA0) begin
                    if (a != vaddr) bad_resume++;
                    vfail = (ecount < need(a));
                    bus_rdata <= vfail ? 8'h5A : 8'hFF;
                end
            end
        end else bus_ack <= 1'b0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int s, input int f, input int exp_st, input int exp_p);
        int n;
        scen = s; fault = f;
        @(negedge clk) clr_stub = 1'b1;
        @(negedge clk) clr_stub = 1'b0;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(done == 1'b0, "R8 start clears done", int'(done), 0);
        n = 0;
        while (!done && n < 40000) begin @(negedge clk); n++; end
        chk(done == 1'b1, "R8 done reached", int'(done), 1);
        chk(int'(status) == exp_st, "R8 status", int'(status), exp_st);
        chk(int'(pulse_cnt) == exp_p, "R7 pulse_cnt", int'(pulse_cnt), exp_p);
        chk(ecount == exp_p, "R3 erase starts seen by stub", ecount, exp_p);
        chk(rcmd_seen == 1, "R8 read command count", rcmd_seen, 1);
        chk(bad_order == 0, "R1 erase before full precondition", bad_order, 0);
        chk(bad_pdata == 0, "R1 program data not 00h", bad_pdata, 0);
        chk(bad_width == 0, "R4 pulse width too short", bad_width, 0);
        chk(bad_resume == 0, "R5 R6 verify address order", bad_resume, 0);
        if (f >= 0)
            chk(fault_tries == PROG_TRIES, "R2 program attempts", fault_tries, PROG_TRIES);
        else
            chk(pver_seen == DEPTH, "R1 one program verify per byte", pver_seen, DEPTH);
    endtask

    initial begin
        int n;
        n = 0;
        while (n < 150000) begin @(posedge clk); n++; end
        chk(1'b0, "watchdog", n, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clr_stub = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clr_stub = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(done == 1'b0, "R10 done", int'(done), 0);
        chk(status == 2'd0, "R10 status", int'(status), 0);
        chk(pulse_cnt == '0, "R10 pulse_cnt", int'(pulse_cnt), 0);
        chk(bus_req == 1'b0, "R10 bus_req", int'(bus_req), 0);
        run(1, -1, 1, 1);   // single pulse erases all
        run(2, -1, 1, 4);   // R6 resumes at 5 and 11, pulses = max need
        run(3, -1, 2, MAX_PULSES); // R7 stuck byte exhausts pulse limit
        run(1, 9, 3, 0);    // R2 byte 9 never programs
        run(2, -1, 1, 4);   // rerun after abort clears result
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule